// File: doc/BRIEF.md
# Iterative add-rotate-xor block encryption core

This core encrypts one 64-bit block under a 128-bit key. It uses a Feistel-like cipher built from three operations on 32-bit words: modular addition, rotation and exclusive-or. The block is kept as two words. In each round the pair is updated with the current round key. The core runs one round per clock and executes 27 rounds.

Round keys are not stored. The core derives them on the fly with a second copy of the same add-rotate-xor round. In that copy the round counter takes the place of the round key. The derived words feed a short shift line, and each word is used three rounds after it is produced.

A host places the key and plaintext on the input buses and pulses `start` while the core is idle. When the run ends, `done` pulses for one cycle. The ciphertext stays on `ct_out` until the next accepted start.

Top module: `arx_block_core`

## Requirements
- R1: After reset, `busy` is 0, `done` is 0 and `ct_out` is all zeros.
- R2: A `start` seen high at a clock edge while `busy` is 0 captures the inputs and sets `busy` at that edge. The input fields are: `key_in[31:0]` is the first round key, `key_in[63:32]`, `key_in[95:64]` and `key_in[127:96]` are the three seed words of the key line in order of use, `pt_in[63:32]` is word X and `pt_in[31:0]` is word Y.
- R3: Each round sets X to ((X rotated right by 8) + Y mod 2^32) xor K. It then sets Y to (Y rotated left by 3) xor the new X. K is the round key of that round.
- R4: The next key-line word is (K + (oldest key-line word rotated right by 8)) xor i, where i is the round index counted from 0. The next round key is (K rotated left by 3) xor that new word. The new word enters the back of the line, and the oldest word leaves it.
- R5: Under key 0x1b1a1918_13121110_0b0a0908_03020100 with plaintext 0x3b726574_7475432d, the ciphertext is 0x8c6fa548_454e028b.
- R6: `done` goes high exactly 27 clock edges after the edge that accepts `start`. `busy` goes low at that same edge, and `ct_out` then holds the ciphertext {X, Y}.
- R7: `done` is high for exactly one cycle.
- R8: While `busy` is 1, `start` and any changes on `key_in` or `pt_in` are ignored. The running result is unchanged, and no extra `done` pulse occurs.
- R9: While idle, `ct_out` holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an encryption when idle |
| key_in | input | 128 | Key: round key 0 in the low word, key-line seeds above it |
| pt_in | input | 64 | Plaintext block, word X in the high half |
| ct_out | output | 64 | Ciphertext block, word X in the high half |
| busy | output | 1 | Rounds in progress |
| done | output | 1 | One-cycle pulse when the ciphertext is ready |

## Verification
The bench builds the core with its default parameters: 32-bit words, four key words, rotations of 8 and 3, and 27 rounds. With these values the known-answer vector applies exactly, and the full key line is exercised. A reference model written in the bench predicts the results for zero, all-ones and mixed patterns. Every run also checks the round latency, the one-cycle done pulse and the output hold. One run sends a second start together with new inputs in the middle of a run, and the bench checks that the result and the number of done pulses are unaffected.

// File: rtl/arx_pkg.sv
package arx_pkg;
    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_RUN  = 1'b1
    } phase_e;

    localparam int unsigned DEF_WORD   = 32;
    localparam int unsigned DEF_KWORDS = 4;
    localparam int unsigned DEF_ROUNDS = 27;
    localparam int unsigned DEF_ROTR   = 8;
    localparam int unsigned DEF_ROTL   = 3;
endpackage

// File: rtl/arx_round.sv
module arx_round #(
    parameter int unsigned W    = 32,
    parameter int unsigned ROTR = 8,
    parameter int unsigned ROTL = 3
) (
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    input  logic [W-1:0] mix_in,
    output logic [W-1:0] a_out,
    output logic [W-1:0] b_out
);
    logic [W-1:0] a_rot;
    logic [W-1:0] b_rot;
    logic [W-1:0] sum;

    always_comb begin
        a_rot = (a_in >> ROTR) | (a_in << (W - ROTR));
        sum   = a_rot + b_in;
        a_out = sum ^ mix_in;
        b_rot = (b_in << ROTL) | (b_in >> (W - ROTL));
        b_out = b_rot ^ a_out;
    end
endmodule

// File: rtl/arx_key_line.sv
module arx_key_line #(
    parameter int unsigned W     = 32,
    parameter int unsigned DEPTH = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [DEPTH*W-1:0] seed,
    input  logic               shift,
    input  logic [W-1:0]       push_word,
    output logic [W-1:0]       head
);
    typedef logic [DEPTH-1:0][W-1:0] line_t;

    line_t words_d, words_q;
    line_t shifted;

    // Slot 0 is the oldest word; the new word enters at the top slot.
    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        if (g == DEPTH - 1) begin : g_top
            assign shifted[g] = push_word;
        end else begin : g_mid
            assign shifted[g] = words_q[g+1];
        end
    end

    always_comb begin
        words_d = words_q;
        if (load) begin
            words_d = line_t'(seed);
        end else if (shift) begin
            words_d = shifted;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            words_q <= '0;
        end else begin
            words_q <= words_d;
        end
    end

    assign head = words_q[0];
endmodule

// File: rtl/arx_block_core.sv
module arx_block_core #(
    parameter int unsigned W      = arx_pkg::DEF_WORD,
    parameter int unsigned KWORDS = arx_pkg::DEF_KWORDS,
    parameter int unsigned ROUNDS = arx_pkg::DEF_ROUNDS,
    parameter int unsigned ROTR   = arx_pkg::DEF_ROTR,
    parameter int unsigned ROTL   = arx_pkg::DEF_ROTL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [KWORDS*W-1:0] key_in,
    input  logic [2*W-1:0]    pt_in,
    output logic [2*W-1:0]    ct_out,
    output logic              busy,
    output logic              done
);
    import arx_pkg::*;

    localparam int unsigned LDEPTH = KWORDS - 1;
    localparam int unsigned RW     = $clog2(ROUNDS);
    localparam logic [RW-1:0] LAST = RW'(ROUNDS - 1);

    typedef struct packed {
        phase_e        phase;
        logic [RW-1:0] rnd;
        logic [W-1:0]  x;
        logic [W-1:0]  y;
        logic [W-1:0]  k;
        logic          fin;
    } core_t;

    core_t st_d, st_q;

    logic [W-1:0] nx, ny;
    logic [W-1:0] nl, nk;
    logic [W-1:0] l_head;
    logic [W-1:0] rnd_word;
    logic         accept;
    logic         advance;

    assign rnd_word = {{(W-RW){1'b0}}, st_q.rnd};
    assign accept   = (st_q.phase == PH_IDLE) && start;
    assign advance  = (st_q.phase == PH_RUN);

    arx_round #(.W(W), .ROTR(ROTR), .ROTL(ROTL)) u_data (
        .a_in  (st_q.x),
        .b_in  (st_q.y),
        .mix_in(st_q.k),
        .a_out (nx),
        .b_out (ny)
    );

    // The same structure derives the schedule; the round index stands in for the key.
    arx_round #(.W(W), .ROTR(ROTR), .ROTL(ROTL)) u_sched (
        .a_in  (l_head),
        .b_in  (st_q.k),
        .mix_in(rnd_word),
        .a_out (nl),
        .b_out (nk)
    );

    arx_key_line #(.W(W), .DEPTH(LDEPTH)) u_line (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .seed     (key_in[KWORDS*W-1:W]),
        .shift    (advance),
        .push_word(nl),
        .head     (l_head)
    );

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        if (accept) begin
            st_d.phase = PH_RUN;
            st_d.rnd   = '0;
            st_d.x     = pt_in[2*W-1:W];
            st_d.y     = pt_in[W-1:0];
            st_d.k     = key_in[W-1:0];
        end else if (advance) begin
            st_d.x = nx;
            st_d.y = ny;
            st_d.k = nk;
            if (st_q.rnd == LAST) begin
                st_d.phase = PH_IDLE;
                st_d.fin   = 1'b1;
            end else begin
                st_d.rnd = st_q.rnd + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, rnd: '0, x: '0, y: '0, k: '0, fin: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign ct_out = {st_q.x, st_q.y};
    assign busy   = (st_q.phase == PH_RUN);
    assign done   = st_q.fin;
endmodule

// File: rtl/arx_block_core_chk.sv
module arx_block_core_chk #(
    parameter int unsigned CTW    = 64,
    parameter int unsigned ROUNDS = 27
) (
    input logic           clk,
    input logic           rst_n,
    input logic           start,
    input logic [CTW-1:0] ct_out,
    input logic           busy,
    input logic           done
);
    localparam int unsigned CW = $clog2(ROUNDS + 1) + 1;

    logic [CW-1:0] run_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_cnt <= '0;
        end else if (start && !busy) begin
            run_cnt <= '0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n) (start && !busy) |=> busy); // R2
    AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n) done |-> (run_cnt == CW'(ROUNDS))); // R6
    AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n) done |-> !busy); // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R7
    AST_CT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy && !start) |=> $stable(ct_out)); // R9
endmodule

bind arx_block_core arx_block_core_chk #(.CTW(2*W), .ROUNDS(ROUNDS)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .ct_out(ct_out),
    .busy  (busy),
    .done  (done)
);

// File: tb/arx_block_core_bench.sv
`timescale 1ns/1ps
module arx_block_core_bench;
    localparam int ROUNDS = 27;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [127:0] key_in = '0;
    logic [63:0]  pt_in = '0;
    logic [63:0]  ct_out;
    logic         busy;
    logic         done;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [63:0] exp_q[$];

    always #2.5 clk = ~clk;

    arx_block_core u_arx_block_core (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .key_in(key_in),
        .pt_in (pt_in),
        .ct_out(ct_out),
        .busy  (busy),
        .done  (done)
    );

    function automatic logic [31:0] ror8(input logic [31:0] v);
        return {v[7:0], v[31:8]};
    endfunction

    function automatic logic [31:0] rol3(input logic [31:0] v);
        return {v[28:0], v[31:29]};
    endfunction

    // Reference model written from R3 and R4
    function automatic logic [63:0] model(input logic [127:0] key, input logic [63:0] pt);
        logic [31:0] x, y, k, nl;
        logic [31:0] lw[0:2];
        x = pt[63:32]; y = pt[31:0]; k = key[31:0];
        lw[0] = key[63:32]; lw[1] = key[95:64]; lw[2] = key[127:96];
        for (int i = 0; i < ROUNDS; i++) begin
            x = (ror8(x) + y) ^ k;
            y = rol3(y) ^ x;
            nl = (k + ror8(lw[0])) ^ 32'(i);
            k = rol3(k) ^ nl;
            lw[0] = lw[1]; lw[1] = lw[2]; lw[2] = nl;
        end
        return {x, y};
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each done against the scoreboard head
    always @(negedge clk) begin
        if (rst_n && done) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 extra done", ct_out, 64'h0);
            end else begin
                logic [63:0] e;
                e = exp_q.pop_front();
                check(ct_out === e, "R3/R4/R5 ciphertext", ct_out, e);
            end
        end
    end

    // Driver: push expected value, run, check timing and hold
    task automatic encrypt(input logic [127:0] key, input logic [63:0] pt,
                           input logic [63:0] exp, input bit disturb);
        int n;
        logic [63:0] held;
        @(negedge clk);
        key_in = key; pt_in = pt; start = 1'b1;
        exp_q.push_back(exp);
        @(negedge clk);
        start = 1'b0;
        n = 1;
        check(busy === 1'b1, "R2 busy after start", 64'(busy), 64'd1);
        while (!done && n < 100) begin
            if (disturb && n == 5) begin
                start = 1'b1; key_in = ~key; pt_in = ~pt;
            end else if (disturb && n == 6) begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        check(n == ROUNDS + 1, "R6 latency", 64'(n), 64'(ROUNDS + 1));
        check(busy === 1'b0, "R6 busy low at done", 64'(busy), 64'd0);
        held = ct_out;
        for (int j = 0; j < 4; j++) begin
            @(negedge clk);
            if (j == 0) check(done === 1'b0, "R7 done one cycle", 64'(done), 64'd0);
            key_in = ~key_in; pt_in = ~pt_in;
            check(ct_out === held, "R9 output held", ct_out, held);
        end
    endtask

    initial begin
        #3;
        check(busy === 1'b0, "R1 busy reset", 64'(busy), 64'd0);
        check(done === 1'b0, "R1 done reset", 64'(done), 64'd0);
        check(ct_out === 64'h0, "R1 ct reset", ct_out, 64'h0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R5: known-answer vector
        encrypt(128'h1b1a1918_13121110_0b0a0908_03020100, 64'h3b726574_7475432d,
                64'h8c6fa548_454e028b, 1'b0);
        encrypt('0, '0, model('0, '0), 1'b0);
        encrypt('1, '1, model('1, '1), 1'b0);
        encrypt(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 64'hdead_beef_0bad_f00d,
                model(128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 64'hdead_beef_0bad_f00d), 1'b0);
        // R8: second start and new inputs mid-run are ignored
        encrypt(128'h1b1a1918_13121110_0b0a0908_03020100, 64'h3b726574_7475432d,
                64'h8c6fa548_454e028b, 1'b1);
        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R8 no pending results", 64'(exp_q.size()), 64'd0);
        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'h0, 64'h1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule